// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the 16-bit unsigned product of two 8-bit unsigned operands one multiplier bit at a time. A single-cycle start pulse, given while the block is idle, captures both operands. A Moore controller then steps through the multiplier bits. In each step the multiplicand register moves left by one place and the multiplier register moves right by one place. When the low multiplier bit is one, the current multiplicand is added into the product register.

The loop ends as soon as the remaining multiplier bits are all zero. A small multiplier therefore finishes in fewer cycles than a large one. Completion is marked by a flag that is high for a single cycle, and the product must be taken in that cycle. The 2-bit state code is driven on a port so that the progress of the controller can be watched.

Top module: `shift_add_mul`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `result` equals op_a × op_b (16 bits, no truncation) in the cycle where `valid` is high; for example 0xFF × 0xFF gives 0xFE01.
- R2: `valid` is high for exactly one cycle per multiply, only while `state` reads 3, and the next cycle `state` reads 0 with `valid` low.
- R3: The state encoding is 0 = idle (waiting for start), 1 = loop test, 2 = add-and-shift, 3 = done. Leaving idle always goes to 1, and 2 always returns to 1.
- R4: Let L be the position of the highest set bit of op_b plus one (L = 0 when op_b is 0). `valid` is first seen high 2·L + 2 rising edges after the edge that samples start, counting that edge as the first. For 0xFF × 0xFF this is 18 edges.
- R5: When op_b is zero, the block reaches done with no add steps (2 edges) and the result is 0.
- R6: A start while the state is not idle, including the done cycle itself, has no effect: the product, the latency and the next state are unchanged, and a start in the done cycle does not begin a new multiply.
- R7: After done, `result` holds the product while the block is idle, until the next accepted start.
- R8: While reset is high, `state` is 0, `valid` is low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply; honoured only in idle |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| result | output | 16 | Product register contents |
| valid | output | 1 | High for the one cycle in which the product is final |
| state | output | 2 | Present controller state code |

## Verification
The sensitive overlap is a start request in the cycle where the done flag is high. At that point the controller is about to fall back to idle, and a careless design would either accept the request or disturb the product being delivered. The bench provokes this case by holding start high, with operands that keep changing, for the whole of a multiply, including the done cycle. It then requires that the delivered product and the latency both match the first captured operands, and that the cycle after done reads idle with the product unchanged.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

  // Controller state codes; the encoding is visible on the top-level port.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_STEP = 2'd2,
    ST_DONE = 2'd3
  } shmul_state_e;

endpackage

// File: rtl/shmul_shreg.sv
module shmul_shreg #(
  parameter int W       = 8,
  parameter bit TO_LEFT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] shifted;

  generate
    if (TO_LEFT) begin : g_left
      assign shifted = {q_r[W-2:0], 1'b0};
    end else begin : g_right
      assign shifted = {1'b0, q_r[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (load_i) begin
      q_r <= load_val_i;
    end else if (shift_i) begin
      q_r <= shifted;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
  import shmul_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         b_zero_i,
  output shmul_state_e state_o,
  output logic         load_o,
  output logic         step_o,
  output logic         valid_o
);

  shmul_state_e st_q, st_d;

  // Next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_TEST;
      ST_TEST: st_d = b_zero_i ? ST_DONE : ST_STEP;
      ST_STEP: st_d = ST_TEST;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  // Output logic
  assign load_o  = (st_q == ST_IDLE) && start_i;
  assign step_o  = (st_q == ST_STEP);
  assign valid_o = (st_q == ST_DONE);
  assign state_o = st_q;

  // R2
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));

  // R3
  step_to_test_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STEP) |=> (st_q == ST_TEST));

  // R5
  zero_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TEST && b_zero_i) |=> (st_q == ST_DONE));

  // R3
  idle_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_TEST));

endmodule

// File: rtl/shmul_dpath.sv
module shmul_dpath #(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic [2*OP_W-1:0] prod_o,
  output logic              b_zero_o
);

  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = PROD_W - OP_W;

  // Conditional accumulation: the adder and the sum/hold selection.
  function automatic logic [PROD_W-1:0] accum(input logic [PROD_W-1:0] acc,
                                              input logic [PROD_W-1:0] addend,
                                              input logic              take);
    return take ? (acc + addend) : acc;
  endfunction

  logic [PROD_W-1:0] mcand_q;
  logic [OP_W-1:0]   mplier_q;
  logic [PROD_W-1:0] prod_q, prod_d;
  logic [PROD_W-1:0] a_ext;
  logic              add_evt;

  assign a_ext = {{EXT_W{1'b0}}, op_a_i};

  shmul_shreg #(.W(PROD_W), .TO_LEFT(1'b1)) u_mcand (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .shift_i    (step_i),
    .load_val_i (a_ext),
    .q_o        (mcand_q)
  );

  shmul_shreg #(.W(OP_W), .TO_LEFT(1'b0)) u_mplier (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .shift_i    (step_i),
    .load_val_i (op_b_i),
    .q_o        (mplier_q)
  );

  assign add_evt  = step_i && mplier_q[0];
  assign b_zero_o = (mplier_q == '0);

  always_comb begin
    if (load_i) prod_d = '0;
    else        prod_d = accum(prod_q, mcand_q, add_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= prod_d;
  end

  assign prod_o = prod_q;

  // R1
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (prod_q == '0 && mplier_q == $past(op_b_i)));

  // R4
  mplier_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (mplier_q == ($past(mplier_q) >> 1)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> ($stable(prod_q) && $stable(mplier_q) && $stable(mcand_q)));

  // R1
  skip_add_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !mplier_q[0]) |=> $stable(prod_q));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shmul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] result,
  output logic              valid,
  output logic [1:0]        state
);

  shmul_state_e st;
  logic         load_w;
  logic         step_w;
  logic         b_zero_w;

  shmul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .b_zero_i (b_zero_w),
    .state_o  (st),
    .load_o   (load_w),
    .step_o   (step_w),
    .valid_o  (valid)
  );

  shmul_dpath #(.OP_W(OP_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .step_i   (step_w),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .prod_o   (result),
    .b_zero_o (b_zero_w)
  );

  assign state = st;

  // R2
  valid_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> ($past(st) == ST_TEST));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> $stable(result));

endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [7:0]  op_a, op_b;
  logic [15:0] result;
  logic        valid;
  logic [1:0]  state;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mul u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .result(result), .valid(valid), .state(state)
  );

  function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction

  function automatic int exp_lat(input logic [7:0] b);
    int len = 0;
    for (int i = 0; i < 8; i++) if (b[i]) len = i + 1;
    return 2 * len + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // noisy: keep start high with changing operands all through the run (R6)
  task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input bit noisy);
    int cnt = 0;
    logic [15:0] held;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    forever begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (noisy) begin
        op_a = 8'($urandom); op_b = 8'($urandom); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (valid || cnt > 40) break;
      if (cnt == 1) check(state == 2'd1, "R3", state, 1);
    end
    check(cnt == exp_lat(b), "R4", cnt, exp_lat(b));
    check(result == exp_prod(a, b), "R1", result, exp_prod(a, b));
    check(state == 2'd3, "R2", state, 3);
    held = result;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(state == 2'd0 && !valid, "R2", {state, valid}, 0);
    if (noisy) check(state == 2'd0, "R6", state, 0);
    @(posedge clk);
    @(negedge clk);
    check(result == held && state == 2'd0, "R7", result, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; op_a = 8'h5A; op_b = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8
    check(state == 2'd0 && !valid && result == 16'h0, "R8", result, 0);
    rst = 1'b0;

    run_mul(8'hFF, 8'hFF, 1'b0);   // R1 R4 worst case 0xFE01 in 18
    run_mul(8'h03, 8'h02, 1'b0);   // early exit
    run_mul(8'hFF, 8'h00, 1'b0);   // R5 zero multiplier
    run_mul(8'h00, 8'hFF, 1'b0);   // zero multiplicand, full length
    run_mul(8'h01, 8'h80, 1'b0);
    run_mul(8'h80, 8'h01, 1'b0);
    run_mul(8'hB7, 8'h5C, 1'b1);   // R6 start held through busy and done
    run_mul(8'h12, 8'h00, 1'b1);   // R5 R6 combined

    for (int k = 0; k < 60; k++)
      run_mul(8'($urandom), 8'($urandom), ($urandom % 4) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule